// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block closes out a byte on an I2C master. On an acknowledge command it holds SCL low, drives the chosen acknowledge bit onto SDA and then runs one full SCL pulse. On a stop command it pulls SDA low and then releases SCL and SDA in the order that forms a Stop condition. It only ever pulls the lines low: an output enable of 1 pulls a line low, and 0 leaves it to the pull-up. Both lines are sampled through a two-flop synchronizer. A reloadable down-counter times every phase. Each phase begins only after the synchronized line shows the level the sequencer intended, so a slave that stretches the clock lengthens the high phase.

The sequencer has ten named states. `SQ_IDLE` moves to `SQ_ACK_LOW` on an acknowledge command, or to `SQ_STP_SDA` on a stop command. The acknowledge path is `SQ_ACK_LOW` (count expires) → `SQ_ACK_WAIT` (SCL seen high) → `SQ_ACK_HIGH` (count expires) → `SQ_IDLE`. The stop path is `SQ_STP_SDA` (SDA seen low) → `SQ_STP_LOW` (count expires) → `SQ_STP_WAIT` (SCL seen high) → `SQ_STP_HIGH` (count expires) → `SQ_STP_REL` (SDA and SCL both seen high) → `SQ_STP_TAIL` (count expires) → `SQ_IDLE`.

The block also holds the byte register that software writes for transmission. It raises an interrupt flag at the end of every sequence. It raises a write-collision flag when that register is written while a sequence runs.

Top module: `i2c_endseq`

## Requirements
- R1: After reset, scl_oe, sda_oe, busy, irq_flag, wcol_flag and stop_seen are 0 and tx_byte is 0.
- R2: The cycle after an acknowledge command is accepted in idle, scl_oe is 1 and busy is 1. For the whole acknowledge sequence, sda_oe equals the inverse of ack_value as captured at that command (0 gives ACK with SDA pulled low, 1 gives NACK with SDA released).
- R3: In an acknowledge sequence, scl_oe stays 1 for exactly reload+1 busy cycles and then goes to 0.
- R4: After SCL is released in an acknowledge sequence, the high phase is counted only once the synchronized SCL is high. SCL therefore stays released for reload+4 cycles plus the number of cycles a slave holds SCL low.
- R5: When an acknowledge sequence ends, busy falls, irq_flag is set, and scl_oe stays 1 in idle until a stop completes.
- R6: A stop sequence drives sda_oe=1 and scl_oe=1 at once. It waits until the synchronized SDA is low and then keeps both lines low for reload+1 more cycles, so scl_oe is 1 for reload+4 busy cycles.
- R7: After SCL is released in a stop sequence, SDA stays pulled low until the synchronized SCL is high and a further reload+1 cycles have passed, so sda_oe is 1 for 2·reload+8 busy cycles.
- R8: stop_seen is set one cycle after both synchronized lines are seen high with SDA released. The sequence ends reload+1 cycles later with irq_flag set and both lines released.
- R9: A write to the byte register while busy sets wcol_flag and leaves tx_byte unchanged. A write while idle loads tx_byte.
- R10: irq_flag and wcol_flag stay set until flag_clear. When flag_clear arrives in the same cycle as a setting event, the flag ends up set. stop_seen is cleared when the next sequence starts.
- R11: A command that arrives while busy is ignored. When an acknowledge command and a stop command arrive in the same idle cycle, only the acknowledge sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload | input | RLD_W | Reload value of the phase counter; one phase lasts reload+1 clocks |
| ack_start | input | 1 | Pulse that starts an acknowledge sequence |
| stop_start | input | 1 | Pulse that starts a Stop sequence |
| ack_value | input | 1 | Acknowledge bit to send: 0 for ACK, 1 for NACK |
| buf_wr | input | 1 | Write strobe for the transmit byte register |
| buf_wdata | input | DATA_W | Data for the transmit byte register |
| flag_clear | input | 1 | Clears irq_flag and wcol_flag |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A sequence is in progress |
| irq_flag | output | 1 | Sticky end-of-sequence flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| stop_seen | output | 1 | Stop condition observed on the bus |
| tx_byte | output | DATA_W | Current content of the transmit byte register |

## Verification
Two things can land on the same clock edge: a sequence completing, which sets irq_flag, and a software action, either a flag_clear strobe or a byte-register write. The bench counts cycles from the command to the edge on which the sequence completes, which is 2·reload+5 cycles for an acknowledge. It then drives flag_clear and buf_wr together so that both are sampled on that completion edge. The expected result is that irq_flag and wcol_flag are both set, tx_byte holds its earlier value and busy has fallen. A second case issues a stop command while an acknowledge runs, and an acknowledge and a stop command in the same cycle. The lengths of the line phases and stop_seen show which sequence actually ran.

// File: rtl/i2c_endseq_pkg.sv
package i2c_endseq_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_ACK_LOW,
        SQ_ACK_WAIT,
        SQ_ACK_HIGH,
        SQ_STP_SDA,
        SQ_STP_LOW,
        SQ_STP_WAIT,
        SQ_STP_HIGH,
        SQ_STP_REL,
        SQ_STP_TAIL
    } seq_state_e;

    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    output logic [LINES-1:0] line_s
);

    logic [LINES-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '1;
                end else begin
                    if (g == 0) begin
                        stage_q[g] <= line_in;
                    end else begin
                        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                    end
                end
            end
        end
    endgenerate

    assign line_s = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_brg_counter.sv
module i2c_brg_counter #(
    parameter int unsigned RLD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [RLD_W-1:0] reload,
    output logic             tc
);

    logic [RLD_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tc = run && (cnt_q == '0);

endmodule

// File: rtl/i2c_endseq_fsm.sv
module i2c_endseq_fsm
    import i2c_endseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_req,
    input  logic stop_req,
    input  logic ack_value,
    input  logic scl_s,
    input  logic sda_s,
    input  logic tc,
    output logic load,
    output logic run,
    output logic scl_oe,
    output logic sda_oe,
    output logic busy,
    output logic done,
    output logic stop_hit,
    output logic seq_start
);

    seq_state_e state_q, state_d;
    logic       ack_drive_q;
    logic       hold_low_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured acknowledge level and idle SCL hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_drive_q <= 1'b0;
            hold_low_q  <= 1'b0;
        end else begin
            if (state_q == SQ_IDLE && ack_req) begin
                ack_drive_q <= ~ack_value;
            end
            if (done && state_q == SQ_ACK_HIGH) begin
                hold_low_q <= 1'b1;
            end else if (done && state_q == SQ_STP_TAIL) begin
                hold_low_q <= 1'b0;
            end
        end
    end

    // transitions
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        done     = 1'b0;
        stop_hit = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (ack_req) begin
                    state_d = SQ_ACK_LOW;
                    load    = 1'b1;
                end else if (stop_req) begin
                    state_d = SQ_STP_SDA;
                end
            end
            SQ_ACK_LOW:  if (tc) state_d = SQ_ACK_WAIT;
            SQ_ACK_WAIT: begin
                if (scl_s) begin
                    state_d = SQ_ACK_HIGH;
                    load    = 1'b1;
                end
            end
            SQ_ACK_HIGH: begin
                if (tc) begin
                    state_d = SQ_IDLE;
                    done    = 1'b1;
                end
            end
            SQ_STP_SDA: begin
                if (!sda_s) begin
                    state_d = SQ_STP_LOW;
                    load    = 1'b1;
                end
            end
            SQ_STP_LOW:  if (tc) state_d = SQ_STP_WAIT;
            SQ_STP_WAIT: begin
                if (scl_s) begin
                    state_d = SQ_STP_HIGH;
                    load    = 1'b1;
                end
            end
            SQ_STP_HIGH: if (tc) state_d = SQ_STP_REL;
            SQ_STP_REL: begin
                if (sda_s && scl_s) begin
                    state_d  = SQ_STP_TAIL;
                    load     = 1'b1;
                    stop_hit = 1'b1;
                end
            end
            SQ_STP_TAIL: begin
                if (tc) begin
                    state_d = SQ_IDLE;
                    done    = 1'b1;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        run    = 1'b0;
        unique case (state_q)
            SQ_IDLE:     scl_oe = hold_low_q;
            SQ_ACK_LOW:  begin scl_oe = 1'b1; sda_oe = ack_drive_q; run = 1'b1; end
            SQ_ACK_WAIT: sda_oe = ack_drive_q;
            SQ_ACK_HIGH: begin sda_oe = ack_drive_q; run = 1'b1; end
            SQ_STP_SDA:  begin scl_oe = 1'b1; sda_oe = 1'b1; end
            SQ_STP_LOW:  begin scl_oe = 1'b1; sda_oe = 1'b1; run = 1'b1; end
            SQ_STP_WAIT: sda_oe = 1'b1;
            SQ_STP_HIGH: begin sda_oe = 1'b1; run = 1'b1; end
            SQ_STP_REL:  ;
            SQ_STP_TAIL: run = 1'b1;
            default:     ;
        endcase
    end

    assign busy      = (state_q != SQ_IDLE);
    assign seq_start = (state_q == SQ_IDLE) && (ack_req || stop_req);

    // R2: accepted acknowledge holds SCL low and drives the captured bit
    p_ack_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE && ack_req) |=> (scl_oe && (sda_oe == !$past(ack_value))));

    // R4: the high phase waits for the synchronized SCL
    p_wait_scl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_ACK_WAIT && !scl_s) |=> (state_q == SQ_ACK_WAIT));

    // R6: the stop keeps SDA low until it is seen low
    p_stop_sda_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_STP_SDA && sda_s) |=> (sda_oe && scl_oe));

endmodule

// File: rtl/i2c_endseq_flags.sv
module i2c_endseq_flags #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              done,
    input  logic              stop_hit,
    input  logic              seq_start,
    input  logic              flag_clear,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    output logic              irq_flag,
    output logic              wcol_flag,
    output logic              stop_seen,
    output logic [DATA_W-1:0] tx_byte
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_flag  <= 1'b0;
            wcol_flag <= 1'b0;
            stop_seen <= 1'b0;
            tx_byte   <= '0;
        end else begin
            if (done) begin
                irq_flag <= 1'b1;
            end else if (flag_clear) begin
                irq_flag <= 1'b0;
            end
            if (buf_wr && busy) begin
                wcol_flag <= 1'b1;
            end else if (flag_clear) begin
                wcol_flag <= 1'b0;
            end
            if (stop_hit) begin
                stop_seen <= 1'b1;
            end else if (seq_start) begin
                stop_seen <= 1'b0;
            end
            if (buf_wr && !busy) begin
                tx_byte <= buf_wdata;
            end
        end
    end

    // R9: a collision is flagged and the byte is kept
    p_wcol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && busy) |=> wcol_flag);
    p_byte_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && busy) |=> $stable(tx_byte));

    // R10: a clear in the completion cycle leaves the flag set
    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> irq_flag);

endmodule

// File: rtl/i2c_endseq.sv
module i2c_endseq
    import i2c_endseq_pkg::*;
#(
    parameter int unsigned RLD_W  = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RLD_W-1:0]  reload,
    input  logic              ack_start,
    input  logic              stop_start,
    input  logic              ack_value,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              flag_clear,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic              irq_flag,
    output logic              wcol_flag,
    output logic              stop_seen,
    output logic [DATA_W-1:0] tx_byte
);

    localparam int unsigned LINES = 2;

    logic [LINES-1:0] lines_s;
    logic             load, run, tc, done, stop_hit, seq_start;

    i2c_line_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in ({scl_in, sda_in}),
        .line_s  (lines_s)
    );

    i2c_brg_counter #(.RLD_W(RLD_W)) u_brg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .run    (run),
        .reload (reload),
        .tc     (tc)
    );

    i2c_endseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_req   (ack_start),
        .stop_req  (stop_start),
        .ack_value (ack_value),
        .scl_s     (lines_s[1]),
        .sda_s     (lines_s[0]),
        .tc        (tc),
        .load      (load),
        .run       (run),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .busy      (busy),
        .done      (done),
        .stop_hit  (stop_hit),
        .seq_start (seq_start)
    );

    i2c_endseq_flags #(.DATA_W(DATA_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .done       (done),
        .stop_hit   (stop_hit),
        .seq_start  (seq_start),
        .flag_clear (flag_clear),
        .buf_wr     (buf_wr),
        .buf_wdata  (buf_wdata),
        .irq_flag   (irq_flag),
        .wcol_flag  (wcol_flag),
        .stop_seen  (stop_seen),
        .tx_byte    (tx_byte)
    );

    // R8: stop_seen rises with both lines released
    p_stop_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_seen) |-> (!scl_oe && !sda_oe && busy));

    // R5: completion always leaves the interrupt flag set
    p_end_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_flag);

endmodule

// File: tb/i2c_endseq_bench.sv
module i2c_endseq_bench;

    localparam int RLD_W  = 8;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [RLD_W-1:0]  reload = 8'd3;
    logic              ack_start = 1'b0;
    logic              stop_start = 1'b0;
    logic              ack_value = 1'b0;
    logic              buf_wr = 1'b0;
    logic [DATA_W-1:0] buf_wdata = '0;
    logic              flag_clear = 1'b0;
    logic              stretch = 1'b0;
    logic              scl_in, sda_in;
    logic              scl_oe, sda_oe, busy, irq_flag, wcol_flag, stop_seen;
    logic [DATA_W-1:0] tx_byte;

    int errors = 0;
    int checks = 0;
    int n_scl_low, n_scl_rel, n_sda_low, n_stop_seen, n_busy;

    always #4 clk = ~clk;

    assign scl_in = ~scl_oe & ~stretch;
    assign sda_in = ~sda_oe;

    i2c_endseq #(.RLD_W(RLD_W), .DATA_W(DATA_W)) u_i2c_endseq (
        .clk(clk), .rst_n(rst_n), .reload(reload),
        .ack_start(ack_start), .stop_start(stop_start), .ack_value(ack_value),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .flag_clear(flag_clear),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .irq_flag(irq_flag),
        .wcol_flag(wcol_flag), .stop_seen(stop_seen), .tx_byte(tx_byte)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // watch a running sequence at negedges until busy falls
    task automatic watch(input int stretch_cycles);
        n_scl_low = 0; n_scl_rel = 0; n_sda_low = 0; n_stop_seen = 0; n_busy = 0;
        for (int i = 0; i < 2000; i++) begin
            if (!busy) break;
            n_busy++;
            if (scl_oe) n_scl_low++; else n_scl_rel++;
            if (sda_oe) n_sda_low++;
            if (stop_seen) n_stop_seen++;
            stretch = (!scl_oe && n_scl_rel <= stretch_cycles && stretch_cycles > 0);
            @(negedge clk);
        end
        stretch = 1'b0;
    endtask

    task automatic clear_flags();
        flag_clear = 1'b1;
        @(negedge clk);
        flag_clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 scl_oe", scl_oe, 0);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 busy", busy, 0);
        check("R1 flags", {irq_flag, wcol_flag, stop_seen}, 0);
        check("R1 tx_byte", tx_byte, 0);
    endtask

    task automatic t_ack(input logic val, input int r, input int s);
        reload = r[RLD_W-1:0];
        ack_value = val;
        ack_start = 1'b1;
        @(negedge clk);
        ack_start = 1'b0;
        ack_value = ~val;
        check("R2 busy", busy, 1);
        check("R2 scl_oe", scl_oe, 1);
        watch(s);
        check("R3 scl low cycles", n_scl_low, r + 1);
        check("R4 scl released cycles", n_scl_rel, r + 4 + s);
        check("R2 sda driven cycles", n_sda_low, val ? 0 : 2 * r + 5 + s);
        check("R5 irq", irq_flag, 1);
        check("R5 scl held", scl_oe, 1);
        repeat (3) @(negedge clk);
        check("R5 scl still held", scl_oe, 1);
        clear_flags();
        check("R10 irq cleared", irq_flag, 0);
    endtask

    task automatic t_stop(input int r);
        reload = r[RLD_W-1:0];
        stop_start = 1'b1;
        @(negedge clk);
        stop_start = 1'b0;
        check("R6 both low at start", {scl_oe, sda_oe}, 3);
        check("R10 stop_seen cleared at start", stop_seen, 0);
        watch(0);
        check("R6 scl low cycles", n_scl_low, r + 4);
        check("R7 sda low cycles", n_sda_low, 2 * r + 8);
        check("R8 stop_seen busy cycles", n_stop_seen, r + 1);
        check("R8 stop_seen", stop_seen, 1);
        check("R8 irq", irq_flag, 1);
        check("R8 lines released", {scl_oe, sda_oe}, 0);
        clear_flags();
    endtask

    task automatic t_wcol();
        buf_wdata = 8'hA5; buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
        check("R9 idle write", tx_byte, 8'hA5);
        check("R9 no wcol idle", wcol_flag, 0);
        reload = 8'd3;
        ack_start = 1'b1;
        @(negedge clk);
        ack_start = 1'b0;
        buf_wdata = 8'h3C; buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0;
        check("R9 wcol set", wcol_flag, 1);
        check("R9 byte kept", tx_byte, 8'hA5);
        watch(0);
        check("R10 wcol sticky", wcol_flag, 1);
        clear_flags();
        check("R10 wcol cleared", wcol_flag, 0);
    endtask

    task automatic t_ignore();
        reload = 8'd4;
        ack_value = 1'b1;
        ack_start = 1'b1; stop_start = 1'b1;
        @(negedge clk);
        ack_start = 1'b0; stop_start = 1'b0;
        check("R11 sda not driven for NACK", sda_oe, 0);
        @(negedge clk);
        stop_start = 1'b1;
        @(negedge clk);
        stop_start = 1'b0;
        watch(0);
        check("R11 ack ran, busy cycles", n_busy, 2 * 4 + 5 - 2);
        check("R11 no stop ran", stop_seen, 0);
        check("R11 scl held after ack", scl_oe, 1);
        clear_flags();
    endtask

    task automatic t_same_cycle();
        reload = 8'd3;
        ack_value = 1'b0;
        ack_start = 1'b1;
        @(negedge clk);
        ack_start = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 busy before completion edge", busy, 1);
        flag_clear = 1'b1; buf_wr = 1'b1; buf_wdata = 8'h11;
        @(negedge clk);
        flag_clear = 1'b0; buf_wr = 1'b0;
        check("R10 busy fell", busy, 0);
        check("R10 irq set wins", irq_flag, 1);
        check("R9 wcol at completion edge", wcol_flag, 1);
        check("R9 byte kept at completion edge", tx_byte, 8'hA5);
        clear_flags();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ack(1'b0, 3, 0);
        t_ack(1'b1, 6, 0);
        t_ack(1'b0, 3, 5);
        repeat (4) @(negedge clk);
        t_stop(3);
        repeat (4) @(negedge clk);
        t_stop(6);
        t_wcol();
        repeat (4) @(negedge clk);
        t_ignore();
        repeat (4) @(negedge clk);
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule